// File: doc/BRIEF.md
# Cache Victim Way Selector

This block decides which way of a set-associative cache set gets replaced when a lookup misses. The miss handler presents the set index, the valid bits of that set's ways and a policy code together with a request strobe; one clock later the chosen way appears on the victim output with a one-cycle valid flag. Tag storage, data arrays and the miss sequence itself live elsewhere.

To choose well, the block watches traffic. Every hit reports the way that hit, and every fill reports the way that was written. From these reports it keeps three kinds of per-set state: a recency order over all ways, the single most recently used way, and the order in which ways were filled. A 16-bit pseudo-random generator supplies the random choices. Its sequence is fixed, so a test run can be replayed exactly.

The policy is chosen per request. Four policies are offered: oldest use, pure pseudo-random, pseudo-random that excludes the most recently used way, and oldest fill. Any invalid way in the set is filled first, whatever the policy.

Top module: `victim_sel`

## Requirements
- R1: After reset `victim_vld_o` is 0 and `victim_o` is 0. In every set, the recency order, the fill order and the most-recently-used way all start at way 0. So the first request to an untouched, fully valid set returns way 0 under policies 0 and 3.
- R2: `victim_vld_o` is 1 in exactly the cycle after a cycle with `req_i` high. `victim_o` changes only in the cycle after a request and otherwise keeps its last value. A request uses the state as it stood before that cycle's hit or fill update.
- R3: If `valid_i` has any 0 bit, the victim is the lowest-numbered way whose valid bit is 0, under every policy.
- R4: Policy code 0 (oldest use) selects the way whose last hit or fill is the oldest in the set. Among ways never touched since reset, it selects the lowest-numbered one.
- R5: Policy code 1 (random) selects the low log2(WAYS) bits of a 16-bit LFSR. The LFSR is seeded to 16'hACE1 by reset. On every request cycle it advances once: the new value is {s[14:0], s[15]^s[13]^s[12]^s[10]}. The value used by a request is the one held before that request's advance.
- R6: Policy code 2 (not most recent) takes the same LFSR bits as R5 as a candidate way r. If r equals the set's most recently used way, the victim is r XOR 1; otherwise it is r. The victim is never the most recently used way.
- R7: Policy code 3 (oldest fill) selects the way whose last fill is the oldest in the set, with never-filled ways ranked lowest-numbered first. Hits do not change this order.
- R8: A hit (`hit_i`) sets that set's most recently used way and refreshes the way's recency. A fill (`fill_i`) does the same and also refreshes the fill order. When `fill_i` and `hit_i` are both high in one cycle, only the fill is applied and the hit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_i | input | log2(SETS) | Set index for the request, hit and fill of this cycle |
| req_i | input | 1 | Victim request strobe (miss) |
| valid_i | input | WAYS | Valid bits of the ways in the requested set |
| policy_i | input | 2 | Policy code: 0 oldest use, 1 random, 2 not most recent, 3 oldest fill |
| hit_i | input | 1 | Hit report strobe |
| hit_way_i | input | log2(WAYS) | Way that hit |
| fill_i | input | 1 | Fill report strobe |
| fill_way_i | input | log2(WAYS) | Way that was filled |
| victim_o | output | log2(WAYS) | Selected victim way |
| victim_vld_o | output | 1 | High for one cycle when victim_o is new |

## Verification
The hardest case to reach is the collision in the not-most-recent policy. Here the generator's low bits land exactly on the set's most recently used way, so the substitution must happen. The same difficulty applies to a fully ordered recency state, in which every way of one set has been touched in a known order. To reach both, the random phase confines most traffic to four sets and mixes many hits and fills with requests. Directed sequences add an explicit fill order followed by a hit that must not disturb it, a hit and a fill in the same cycle, and partially valid sets.

// File: rtl/vs_pkg.sv
package vs_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_RAND = 2'd1,
    POL_NMRU = 2'd2,
    POL_FIFO = 2'd3
  } vs_policy_e;
endpackage

// File: rtl/vs_age_order.sv
// Per-set age matrix: bit [s][i][j] set means way i was touched after way j.
module vs_age_order #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] rd_set,
  output logic [WAY_W-1:0] oldest_o
);
  logic [SETS-1:0][WAYS-1:0][WAYS-1:0] mat_q, mat_d;

  always_comb begin
    mat_d = mat_q;
    if (touch_en) begin
      for (int i = 0; i < WAYS; i++) mat_d[touch_set][i][touch_way] = 1'b0;
      mat_d[touch_set][touch_way] = ~(WAYS'(1) << touch_way);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mat_q <= '0;
    else if (touch_en) mat_q <= mat_d;
  end

  // The oldest way has an all-zero row; ties resolve to the lowest index.
  always_comb begin
    oldest_o = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (mat_q[rd_set][i] == '0) oldest_o = WAY_W'(i);
  end
endmodule

// File: rtl/vs_lfsr.sv
module vs_lfsr #(
  parameter int          OUT_W = 2,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  output logic [OUT_W-1:0] rnd_o
);
  logic [15:0] st_q, st_d;

  always_comb st_d = {st_q[14:0], st_q[15] ^ st_q[13] ^ st_q[12] ^ st_q[10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= SEED;
    else if (en) st_q <= st_d;
  end

  assign rnd_o = st_q[OUT_W-1:0];
endmodule

// File: rtl/victim_sel.sv
module victim_sel
  import vs_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             req_i,
  input  logic [WAYS-1:0]  valid_i,
  input  logic [1:0]       policy_i,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             victim_vld_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  logic             use_en;
  logic [WAY_W-1:0] use_way;
  logic [WAY_W-1:0] lru_way, fifo_way, rnd_way, mru_rd;

  assign use_en  = fill_i | hit_i;
  assign use_way = fill_i ? fill_way_i : hit_way_i;

  vs_age_order #(.WAYS(WAYS), .SETS(SETS)) u_use_order (
    .clk(clk), .rst_n(rst_sync_n), .touch_en(use_en), .touch_set(set_i),
    .touch_way(use_way), .rd_set(set_i), .oldest_o(lru_way)
  );

  vs_age_order #(.WAYS(WAYS), .SETS(SETS)) u_fill_order (
    .clk(clk), .rst_n(rst_sync_n), .touch_en(fill_i), .touch_set(set_i),
    .touch_way(fill_way_i), .rd_set(set_i), .oldest_o(fifo_way)
  );

  vs_lfsr #(.OUT_W(WAY_W), .SEED(16'hACE1)) u_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .en(req_i), .rnd_o(rnd_way)
  );

  logic [SETS-1:0][WAY_W-1:0] mru_q, mru_d;

  always_comb begin
    mru_d = mru_q;
    if (use_en) mru_d[set_i] = use_way;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  mru_q <= '0;
    else if (use_en)  mru_q <= mru_d;
  end

  assign mru_rd = mru_q[set_i];

  logic             inv_any;
  logic [WAY_W-1:0] inv_way, nmru_way, pick_way;

  always_comb begin
    inv_any = 1'b0;
    inv_way = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!valid_i[i]) begin
        inv_any = 1'b1;
        inv_way = WAY_W'(i);
      end
    nmru_way = (rnd_way == mru_rd) ? (rnd_way ^ WAY_W'(1)) : rnd_way;
    case (vs_policy_e'(policy_i))
      POL_LRU:  pick_way = lru_way;
      POL_RAND: pick_way = rnd_way;
      POL_NMRU: pick_way = nmru_way;
      default:  pick_way = fifo_way;
    endcase
    if (inv_any) pick_way = inv_way;
  end

  logic [WAY_W-1:0] victim_q, victim_d;
  logic             vld_q;

  assign victim_d = req_i ? pick_way : victim_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      victim_q <= '0;
      vld_q    <= 1'b0;
    end else begin
      victim_q <= victim_d;
      vld_q    <= req_i;
    end
  end

  assign victim_o     = victim_q;
  assign victim_vld_o = vld_q;
endmodule

// File: rtl/vs_chk.sv
module vs_chk #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic [WAYS-1:0]  valid_i,
  input logic [1:0]       policy_i,
  input logic [WAY_W-1:0] mru_rd,
  input logic [WAY_W-1:0] victim_o,
  input logic             victim_vld_o
);
  logic [WAYS-1:0] vprev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vprev_q <= '1;
    else        vprev_q <= valid_i;
  end

  // R2
  vld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> victim_vld_o);

  // R2
  no_vld_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !victim_vld_o);

  // R2
  victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(victim_o));

  // R3
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (valid_i != '1)) |=> !vprev_q[victim_o]);

  // R6
  nmru_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && policy_i == 2'd2 && valid_i == '1) |=> (victim_o != $past(mru_rd)));
endmodule

bind victim_sel vs_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .valid_i(valid_i),
  .policy_i(policy_i), .mru_rd(mru_rd), .victim_o(victim_o),
  .victim_vld_o(victim_vld_o)
);

// File: tb/sim_victim_sel.sv
module sim_victim_sel;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW = 2;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [SW-1:0] set_i;
  logic          req_i, hit_i, fill_i;
  logic [WAYS-1:0] valid_i;
  logic [1:0]    policy_i;
  logic [WW-1:0] hit_way_i, fill_way_i, victim_o;
  logic          victim_vld_o;

  victim_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .req_i(req_i), .valid_i(valid_i),
    .policy_i(policy_i), .hit_i(hit_i), .hit_way_i(hit_way_i), .fill_i(fill_i),
    .fill_way_i(fill_way_i), .victim_o(victim_o), .victim_vld_o(victim_vld_o)
  );

  int errors = 0, checks = 0;
  int ts_use[SETS][WAYS];
  int ts_fill[SETS][WAYS];
  int mru_m[SETS];
  logic [15:0] lf;
  int tick = 0;
  bit pend = 0;
  int pend_exp = 0;
  string pend_tag = "R2";
  int last_vic = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int oldest(input int s, input bit fifo);
    int best = 0;
    for (int w = 1; w < WAYS; w++) begin
      if (fifo) begin
        if (ts_fill[s][w] < ts_fill[s][best]) best = w;
      end else begin
        if (ts_use[s][w] < ts_use[s][best]) best = w;
      end
    end
    return best;
  endfunction

  task automatic cyc(input bit rq, input int st, input logic [WAYS-1:0] vl,
                     input int pol, input bit h, input int hw, input bit f, input int fw);
    int e;
    @(negedge clk);
    chk("R2", int'(victim_vld_o), int'(pend));
    if (pend) begin
      chk(pend_tag, int'(victim_o), pend_exp);
      last_vic = pend_exp;
    end else begin
      chk("R2", int'(victim_o), last_vic);
    end
    set_i = SW'(st); req_i = rq; valid_i = vl; policy_i = 2'(pol);
    hit_i = h; hit_way_i = WW'(hw); fill_i = f; fill_way_i = WW'(fw);
    pend = rq;
    if (rq) begin
      e = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!vl[w]) e = w;
      if (e >= 0) pend_tag = "R3";
      else begin
        case (pol)
          0: begin e = oldest(st, 0); pend_tag = "R4"; end
          1: begin e = int'(lf[WW-1:0]); pend_tag = "R5"; end
          2: begin
            e = int'(lf[WW-1:0]);
            if (e == mru_m[st]) e = e ^ 1;
            pend_tag = "R6";
          end
          default: begin e = oldest(st, 1); pend_tag = "R7"; end
        endcase
      end
      pend_exp = e;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    end
    if (f) begin
      tick++; ts_use[st][fw] = tick; ts_fill[st][fw] = tick; mru_m[st] = fw;
    end else if (h) begin
      tick++; ts_use[st][hw] = tick; mru_m[st] = hw;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < SETS; s++) begin
      mru_m[s] = 0;
      for (int w = 0; w < WAYS; w++) begin ts_use[s][w] = 0; ts_fill[s][w] = 0; end
    end
    lf = 16'hACE1;
    rst_n = 1'b0; set_i = '0; req_i = 0; valid_i = '1; policy_i = 0;
    hit_i = 0; hit_way_i = '0; fill_i = 0; fill_way_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", int'(victim_vld_o), 0);
    chk("R1", int'(victim_o), 0);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, '1, 0, 0, 0, 0, 0);
    // R1: untouched set returns way 0 for oldest-use and oldest-fill
    cyc(1, 0, '1, 0, 0, 0, 0, 0);
    cyc(1, 0, '1, 3, 0, 0, 0, 0);
    cyc(1, 0, '1, 2, 0, 0, 0, 0);
    // R7 / R4: fill order 2,0,3,1 then hit way 2; fifo stays at 2, lru moves
    cyc(0, 5, '1, 0, 0, 0, 1, 2);
    cyc(0, 5, '1, 0, 0, 0, 1, 0);
    cyc(0, 5, '1, 0, 0, 0, 1, 3);
    cyc(0, 5, '1, 0, 0, 0, 1, 1);
    cyc(0, 5, '1, 0, 1, 2, 0, 0);
    cyc(1, 5, '1, 3, 0, 0, 0, 0);
    cyc(1, 5, '1, 0, 0, 0, 0, 0);
    // R8: hit and fill together, only fill applies
    cyc(1, 5, '1, 0, 1, 0, 1, 3);
    cyc(1, 5, '1, 0, 0, 0, 0, 0);
    cyc(1, 5, '1, 2, 0, 0, 0, 0);
    // R3: partially valid sets
    cyc(1, 7, 4'b1011, 0, 0, 0, 0, 0);
    cyc(1, 7, 4'b0000, 3, 0, 0, 0, 0);
    cyc(1, 7, 4'b0111, 1, 0, 0, 0, 0);
    // R5 / R6: back-to-back random requests
    for (int k = 0; k < 8; k++) cyc(1, 5, '1, 1 + (k % 2), 0, 0, 0, 0);
    // random mix, mostly four sets
    for (int k = 0; k < 4000; k++) begin
      int st, pol, hw, fw;
      bit rq, h, f;
      logic [WAYS-1:0] vl;
      st  = ($urandom % 4 != 0) ? int'($urandom % 4) : int'($urandom % SETS);
      rq  = ($urandom % 2) == 0;
      vl  = ($urandom % 4 != 0) ? '1 : WAYS'($urandom);
      pol = int'($urandom % 4);
      h   = ($urandom % 5) < 2;
      f   = ($urandom % 4) == 0;
      hw  = int'($urandom % WAYS);
      fw  = int'($urandom % WAYS);
      cyc(rq, st, vl, pol, h, hw, f, fw);
    end
    repeat (2) cyc(0, 0, '1, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule